// File: doc/BRIEF.md
# Command Descriptor Intake Sequencer

This block sits between a host register interface and a packet processing engine. For each packet the host writes a control word, optionally a user identifier, and a length word. It then commits the descriptor by writing the value 1 to a count register. At the commit the block checks the captured descriptor. A bad descriptor puts the sequencer into an error state. A good one makes it wait for the host to report that the packet's security association is ready.

When the ready write arrives, the block issues a single-cycle start pulse to the engine, carrying the captured fields. It then clears its per-packet state and becomes idle again. Writes that break the expected order are refused and reported through sticky error flags. The host clears these flags by writing ones to a status register. Clearing the invalid-descriptor flag also takes the sequencer out of its error state.

Every input is a one-cycle write strobe with its data. Every output comes from a register.

Top module: `cis_cmd_intake`

## Requirements
- R1: After a synchronous reset, `start` is low, `waiting_sa` is low, `err_flags` is 0 and the sequencer is idle.
- R2: In the idle state, a control, user-id or length write captures its data. The user id is optional: a packet whose user id was never written starts with a user id of 0.
- R3: In the idle state, a count write with value 1 validates the descriptor. The descriptor is valid when a control word was written since the last packet, the length is nonzero, and the length is at most MAX_LEN. An invalid descriptor sets err_flags bit 0 on the next cycle and holds the sequencer in an error state in which `waiting_sa` stays low.
- R4: In the idle state, a count write with any value other than 1 changes no state except that it sets err_flags bit 1.
- R5: A valid commit raises `waiting_sa` on the next cycle.
- R6: A ready write while `waiting_sa` is high raises `start` for exactly one cycle, starting the next cycle. In that cycle `start_ctl`, `start_uid` and `start_len` carry the captured descriptor and `waiting_sa` is already low.
- R7: After a start, the control-written flag, user id and length are cleared, so a new commit with no new control write is invalid.
- R8: A control, user-id, length or count write is rejected when it arrives while the sequencer waits for the ready write, while it is in the error state, or in the same cycle as a count write. A rejected write leaves the descriptor unchanged and sets err_flags bit 2.
- R9: A ready write when `waiting_sa` is low is ignored and sets err_flags bit 1.
- R10: A status write clears each err_flags bit whose data bit is 1. A flag set in the same cycle stays set. Clearing bit 0 in the error state returns the sequencer to idle with the descriptor cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word data |
| uid_wr | input | 1 | User identifier write strobe |
| uid_wdata | input | UID_W | User identifier data |
| len_wr | input | 1 | Length write strobe |
| len_wdata | input | LEN_W | Packet length |
| cnt_wr | input | 1 | Count (commit) write strobe |
| cnt_wdata | input | CNT_W | Count value; 1 commits |
| sa_rdy_wr | input | 1 | Security-association-ready write strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Write-one-to-clear mask for err_flags |
| start | output | 1 | One-cycle packet start pulse |
| start_ctl | output | CTL_W | Control word issued with start |
| start_uid | output | UID_W | User identifier issued with start |
| start_len | output | LEN_W | Length issued with start |
| waiting_sa | output | 1 | Committed descriptor waits for the ready write |
| err_flags | output | 3 | Sticky flags: bit 0 invalid descriptor, bit 1 protocol, bit 2 rejected write |

## Verification
The bench tests the length bounds: a length of exactly MAX_LEN must be accepted, while MAX_LEN+1 and 0 must land in the error state. A design with an off-by-one comparison would accept or refuse the wrong packet. It commits a second packet without a new control word, which catches a sequencer that keeps the control-written flag after a start. It writes during the wait and the error state, and in the same cycle as a commit, then checks that the start carries the original fields; a design that accepts these writes would issue corrupted descriptors. It also clears a flag in the same cycle as that flag is set, and clears the rejected-write flag without the invalid-descriptor flag. A design that gives clearing priority would lose an error, and one that leaves the error state on any status write would restart too early.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ERR  = 2'd2
  } cis_state_e;

  localparam int ERR_W     = 3;
  localparam int ERR_INVAL = 0;
  localparam int ERR_PROTO = 1;
  localparam int ERR_REJ   = 2;
endpackage

// File: rtl/cis_desc_regs.sv
module cis_desc_regs #(
  parameter int CTL_W = 32,
  parameter int UID_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_d,
  input  logic             uid_we,
  input  logic [UID_W-1:0] uid_d,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_d,
  output logic [CTL_W-1:0] ctl_q,
  output logic [UID_W-1:0] uid_q,
  output logic [LEN_W-1:0] len_q,
  output logic             ctl_seen
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctl_q    <= '0;
      uid_q    <= '0;
      len_q    <= '0;
      ctl_seen <= 1'b0;
    end else begin
      if (ctl_we) begin
        ctl_q    <= ctl_d;
        ctl_seen <= 1'b1;
      end
      if (uid_we) uid_q <= uid_d;
      if (len_we) len_q <= len_d;
    end
  end

  // R7: a clear leaves no trace of the previous packet
  a_r7_clear_flag: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!ctl_seen && uid_q == '0 && len_q == '0));
  // R8: without a write enable the stored fields hold
  a_r8_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ctl_we && !len_we) |=> ($stable(ctl_q) && $stable(len_q)));
endmodule

// File: rtl/cis_check.sv
module cis_check #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 2048
) (
  input  logic             ctl_seen,
  input  logic [LEN_W-1:0] len,
  output logic             desc_ok
);
  localparam logic [LEN_W:0] MAX_EXT = (LEN_W+1)'(MAX_LEN);

  always_comb begin
    desc_ok = ctl_seen && (len != '0) && ({1'b0, len} <= MAX_EXT);
  end
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
  import cis_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_desc_wr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             sa_rdy_wr,
  input  logic             stat_wr,
  input  logic [ERR_W-1:0] stat_wdata,
  input  logic             desc_ok,
  output logic             desc_accept,
  output logic             desc_clr,
  output logic             launch,
  output logic             waiting_sa,
  output logic [ERR_W-1:0] err_flags
);
  localparam logic [CNT_W-1:0] COMMIT_VAL = CNT_W'(1);

  cis_state_e st_q, st_d;
  logic idle_cnt, commit_good, commit_bad, cnt_badval, sa_bad, exit_err, reject;
  logic [ERR_W-1:0] err_set, err_clr;

  always_comb begin
    idle_cnt    = (st_q == ST_IDLE) && cnt_wr;
    commit_good = idle_cnt && (cnt_wdata == COMMIT_VAL) && desc_ok;
    commit_bad  = idle_cnt && (cnt_wdata == COMMIT_VAL) && !desc_ok;
    cnt_badval  = idle_cnt && (cnt_wdata != COMMIT_VAL);
    launch      = (st_q == ST_WAIT) && sa_rdy_wr;
    sa_bad      = (st_q != ST_WAIT) && sa_rdy_wr;
    exit_err    = (st_q == ST_ERR) && stat_wr && stat_wdata[ERR_INVAL];
    desc_accept = (st_q == ST_IDLE) && !cnt_wr;
    reject      = (any_desc_wr && !desc_accept) || (cnt_wr && st_q != ST_IDLE);
    desc_clr    = launch || exit_err;

    err_set            = '0;
    err_set[ERR_INVAL] = commit_bad;
    err_set[ERR_PROTO] = cnt_badval || sa_bad;
    err_set[ERR_REJ]   = reject;
    err_clr            = stat_wr ? stat_wdata : '0;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (commit_good) st_d = ST_WAIT;
               else if (commit_bad) st_d = ST_ERR;
      ST_WAIT: if (launch) st_d = ST_IDLE;
      ST_ERR:  if (exit_err) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign waiting_sa = (st_q == ST_WAIT);

  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)             err_flags[i] <= 1'b0;
      else if (err_set[i]) err_flags[i] <= 1'b1;
      else if (err_clr[i]) err_flags[i] <= 1'b0;
    end
  end

  a_r3_bad_commit: assert property (@(posedge clk) disable iff (rst)
    commit_bad |=> (err_flags[ERR_INVAL] && !waiting_sa));
  a_r4_bad_count: assert property (@(posedge clk) disable iff (rst)
    cnt_badval |=> (err_flags[ERR_PROTO] && st_q == ST_IDLE));
  a_r5_wait_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit_good |=> waiting_sa);
  a_r8_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (any_desc_wr && st_q != ST_IDLE) |=> err_flags[ERR_REJ]);
  a_r9_stray_ready: assert property (@(posedge clk) disable iff (rst)
    sa_bad |=> err_flags[ERR_PROTO]);
  a_r10_err_state_flag: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ERR) |-> err_flags[ERR_INVAL]);
endmodule

// File: rtl/cis_cmd_intake.sv
module cis_cmd_intake
  import cis_pkg::*;
#(
  parameter int CTL_W   = 32,
  parameter int UID_W   = 16,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 8,
  parameter int MAX_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             uid_wr,
  input  logic [UID_W-1:0] uid_wdata,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             sa_rdy_wr,
  input  logic             stat_wr,
  input  logic [2:0]       stat_wdata,
  output logic             start,
  output logic [CTL_W-1:0] start_ctl,
  output logic [UID_W-1:0] start_uid,
  output logic [LEN_W-1:0] start_len,
  output logic             waiting_sa,
  output logic [2:0]       err_flags
);
  logic desc_accept, desc_clr, launch, desc_ok, ctl_seen;
  logic [CTL_W-1:0] ctl_q;
  logic [UID_W-1:0] uid_q;
  logic [LEN_W-1:0] len_q;

  cis_desc_regs #(.CTL_W(CTL_W), .UID_W(UID_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .clr(desc_clr),
    .ctl_we(ctl_wr && desc_accept), .ctl_d(ctl_wdata),
    .uid_we(uid_wr && desc_accept), .uid_d(uid_wdata),
    .len_we(len_wr && desc_accept), .len_d(len_wdata),
    .ctl_q(ctl_q), .uid_q(uid_q), .len_q(len_q), .ctl_seen(ctl_seen)
  );

  cis_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_check (
    .ctl_seen(ctl_seen), .len(len_q), .desc_ok(desc_ok)
  );

  cis_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst),
    .any_desc_wr(ctl_wr || uid_wr || len_wr),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .sa_rdy_wr(sa_rdy_wr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .desc_ok(desc_ok), .desc_accept(desc_accept), .desc_clr(desc_clr),
    .launch(launch), .waiting_sa(waiting_sa), .err_flags(err_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start     <= 1'b0;
      start_ctl <= '0;
      start_uid <= '0;
      start_len <= '0;
    end else begin
      start <= launch;
      if (launch) begin
        start_ctl <= ctl_q;
        start_uid <= uid_q;
        start_len <= len_q;
      end
    end
  end

  // R6: the start pulse lasts one cycle and the wait is over when it rises
  a_r6_single_start: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  a_r6_launch_pulse: assert property (@(posedge clk) disable iff (rst)
    (waiting_sa && sa_rdy_wr) |=> (start && !waiting_sa));
endmodule

// File: tb/cis_cmd_intake_bench.sv
module cis_cmd_intake_bench;
  localparam int CTL_W = 32, UID_W = 16, LEN_W = 16, CNT_W = 8, MAX_LEN = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, uid_wr = 0, len_wr = 0, cnt_wr = 0, sa_rdy_wr = 0, stat_wr = 0;
  logic [CTL_W-1:0] ctl_wdata = '0;
  logic [UID_W-1:0] uid_wdata = '0;
  logic [LEN_W-1:0] len_wdata = '0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [2:0]       stat_wdata = '0;
  logic             start, waiting_sa;
  logic [CTL_W-1:0] start_ctl;
  logic [UID_W-1:0] start_uid;
  logic [LEN_W-1:0] start_len;
  logic [2:0]       err_flags;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cis_cmd_intake #(.CTL_W(CTL_W), .UID_W(UID_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .MAX_LEN(MAX_LEN)) u_cis_cmd_intake (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .uid_wr(uid_wr), .uid_wdata(uid_wdata), .len_wr(len_wr), .len_wdata(len_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .sa_rdy_wr(sa_rdy_wr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .start(start),
    .start_ctl(start_ctl), .start_uid(start_uid), .start_len(start_len),
    .waiting_sa(waiting_sa), .err_flags(err_flags)
  );

  // Behavioural reference: mode 0 idle, 1 waiting for ready, 2 error
  int m_mode;
  logic [CTL_W-1:0] m_ctl, m_sctl;
  logic [UID_W-1:0] m_uid, m_suid;
  logic [LEN_W-1:0] m_len, m_slen;
  logic m_seen, m_start;
  logic [2:0] m_err;

  task automatic m_wipe();
    m_ctl = '0; m_uid = '0; m_len = '0; m_seen = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_wipe(); m_start = 0; m_err = '0;
      m_sctl = '0; m_suid = '0; m_slen = '0;
    end else begin
      logic [2:0] e;
      int nm;
      nm = m_mode;
      e = m_err;
      if (stat_wr) e = e & ~stat_wdata;
      m_start = 0;
      if (m_mode == 0) begin
        if (cnt_wr) begin
          if (ctl_wr || uid_wr || len_wr) e[2] = 1;
          if (cnt_wdata != 1) e[1] = 1;
          else if (m_seen && m_len != 0 && int'(m_len) <= MAX_LEN) nm = 1;
          else begin nm = 2; e[0] = 1; end
        end else begin
          if (ctl_wr) begin m_ctl = ctl_wdata; m_seen = 1; end
          if (uid_wr) m_uid = uid_wdata;
          if (len_wr) m_len = len_wdata;
        end
        if (sa_rdy_wr) e[1] = 1;
      end else begin
        if (ctl_wr || uid_wr || len_wr || cnt_wr) e[2] = 1;
        if (m_mode == 1) begin
          if (sa_rdy_wr) begin
            m_start = 1; m_sctl = m_ctl; m_suid = m_uid; m_slen = m_len;
            m_wipe(); nm = 0;
          end
        end else begin
          if (sa_rdy_wr) e[1] = 1;
          if (stat_wr && stat_wdata[0]) begin m_wipe(); nm = 0; end
        end
      end
      m_mode = nm;
      m_err = e;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(start == m_start, "R6 start", start, m_start);
      if (m_start) begin
        chk(start_ctl == m_sctl, "R6 start_ctl", start_ctl, m_sctl);
        chk(start_uid == m_suid, "R2 start_uid", start_uid, m_suid);
        chk(start_len == m_slen, "R6 start_len", start_len, m_slen);
      end
      chk(waiting_sa == (m_mode == 1), "R5 waiting_sa", waiting_sa, m_mode == 1);
      chk(err_flags[0] == m_err[0], "R3 err bit0", err_flags[0], m_err[0]);
      chk(err_flags[1] == m_err[1], "R4 err bit1", err_flags[1], m_err[1]);
      chk(err_flags[2] == m_err[2], "R8 err bit2", err_flags[2], m_err[2]);
    end
  end

  // Each task is entered at a falling edge and returns at the next one
  task automatic w_ctl(input logic [CTL_W-1:0] v);
    ctl_wr = 1; ctl_wdata = v; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic w_uid(input logic [UID_W-1:0] v);
    uid_wr = 1; uid_wdata = v; @(negedge clk); uid_wr = 0;
  endtask
  task automatic w_len(input logic [LEN_W-1:0] v);
    len_wr = 1; len_wdata = v; @(negedge clk); len_wr = 0;
  endtask
  task automatic w_cnt(input logic [CNT_W-1:0] v);
    cnt_wr = 1; cnt_wdata = v; @(negedge clk); cnt_wr = 0;
  endtask
  task automatic w_sa();
    sa_rdy_wr = 1; @(negedge clk); sa_rdy_wr = 0;
  endtask
  task automatic w_stat(input logic [2:0] v);
    stat_wr = 1; stat_wdata = v; @(negedge clk); stat_wr = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!start && !waiting_sa && err_flags == 3'b000, "R1 reset state",
        {start, waiting_sa, err_flags}, 0);

    // Full packet with user id; writes during the wait are refused
    w_ctl(32'hA5A5_0001); w_uid(16'h1234); w_len(16'd100); w_cnt(8'd1);
    chk(waiting_sa == 1, "R5 wait after commit", waiting_sa, 1);
    idle(2);
    w_ctl(32'h0000_FFFF); w_len(16'd5); w_cnt(8'd1);
    chk(err_flags[2] == 1, "R8 rejected in wait", err_flags[2], 1);
    w_sa();
    chk(start && start_ctl == 32'hA5A5_0001 && start_len == 16'd100 && start_uid == 16'h1234,
        "R6 start fields", start_ctl, 32'hA5A5_0001);
    chk(!waiting_sa, "R6 wait dropped", waiting_sa, 0);
    w_stat(3'b100);
    chk(err_flags == 3'b000, "R10 w1c bit2", err_flags, 0);

    // No user id, length at the upper bound
    w_ctl(32'h0BAD_CAFE); w_len(16'(MAX_LEN)); w_cnt(8'd1);
    chk(waiting_sa == 1, "R3 max length accepted", waiting_sa, 1);
    w_sa();
    chk(start_uid == 16'h0 && start_len == 16'(MAX_LEN), "R2 uid defaults to zero",
        start_uid, 0);

    // Commit without a fresh control word
    w_len(16'd10); w_cnt(8'd1);
    chk(err_flags[0] == 1 && !waiting_sa, "R7 stale control rejected", err_flags, 1);
    w_ctl(32'h1111_1111); w_cnt(8'd1);
    chk(err_flags[2] == 1, "R8 rejected in error state", err_flags, 4);
    w_stat(3'b100);
    chk(err_flags[0] == 1 && err_flags[2] == 0, "R10 bit2 clear keeps error", err_flags, 1);
    w_ctl(32'h2222_2222); idle(1);
    w_stat(3'b111);
    chk(err_flags == 3'b000, "R10 exit error state", err_flags, 0);

    // Length zero, then MAX_LEN+1
    w_ctl(32'h3); w_len(16'd0); w_cnt(8'd1);
    chk(err_flags[0] == 1, "R3 zero length", err_flags, 1);
    w_stat(3'b001);
    w_ctl(32'h4); w_len(16'(MAX_LEN + 1)); w_cnt(8'd1);
    chk(err_flags[0] == 1 && !waiting_sa, "R3 length over max", err_flags, 1);
    w_stat(3'b111);

    // Count value other than 1, stray ready write, clear racing a set
    w_ctl(32'h5); w_len(16'd9); w_cnt(8'd2);
    chk(err_flags[1] == 1 && !waiting_sa, "R4 bad count value", err_flags, 2);
    w_stat(3'b010);
    w_sa();
    chk(err_flags[1] == 1 && !start, "R9 stray ready", err_flags, 2);
    stat_wr = 1; stat_wdata = 3'b010; sa_rdy_wr = 1;
    @(negedge clk); stat_wr = 0; sa_rdy_wr = 0;
    chk(err_flags[1] == 1, "R10 set wins over clear", err_flags, 2);
    w_stat(3'b010);
    w_cnt(8'd1);
    chk(waiting_sa == 1, "R4 descriptor kept after bad count", waiting_sa, 1);
    w_sa();
    chk(start_ctl == 32'h5 && start_len == 16'd9, "R4 fields intact", start_ctl, 5);

    // Control write in the same cycle as a commit
    w_ctl(32'h6666_0000); w_len(16'd7);
    ctl_wr = 1; ctl_wdata = 32'h7777_0000; cnt_wr = 1; cnt_wdata = 8'd1;
    @(negedge clk); ctl_wr = 0; cnt_wr = 0;
    chk(waiting_sa == 1 && err_flags[2] == 1, "R8 same-cycle write rejected", err_flags, 4);
    w_sa();
    chk(start_ctl == 32'h6666_0000, "R8 original control issued", start_ctl, 32'h6666_0000);
    idle(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule